// File: doc/BRIEF.md
# Start-of-frame aligned bit extractor

This block works on a receive capture held in two byte-wide memories of equal depth. One memory holds the demodulated data bits. The other holds a validity flag for each of those bits. In both memories, bit position p is stored in byte p/8 at bit 7-(p%8), so the stream reads MSB first. A validity flag of 0 marks a cleanly decoded bit. A flag of 1 marks a bit that is bad or missing, so a cleared capture is all data 0 with all flags 1.

On a start strobe the block finds where the reply begins. The rule depends on the modulation: amplitude keying uses the first clean bit, and frequency keying matches a fixed 4-bit start pattern. The block then checks that the start bit is 1. It takes the bits that follow one per clock and packs them LSB first into bytes, which go out on a write port. Extraction ends at the first bit flagged bad, or when the requested number of bits has been taken. The result gives the count of requested bits that were not extracted, so 0 means the whole request was met.

The read port is asynchronous: `rd_data` and `rd_valid` must show the byte at `rd_addr` within the same cycle.

Top module: `sof_bit_extractor`

## Requirements
- R1: While reset is low and after it is released, `done`, `wr_en` and `found` are 0 and `remain` is 0.
- R2: Bit position p is read from byte p/8 at bit 7-(p%8) of both `rd_data` and `rd_valid`. A `rd_valid` bit of 0 means clean and 1 means bad.
- R3: With `fsk_mode` = 0, the start position is the lowest position from 0 to 6 whose validity bit is 0. Position 7 is never taken as a start.
- R4: With `fsk_mode` = 1, the search looks only at byte 0. If data[7:4] = 4'b0101 and valid[7:4] = 4'b0000, the start is position 3. Otherwise, if data[6:3] = 4'b0101 and valid[6:3] = 4'b0000, the start is position 4. Otherwise no start is found.
- R5: If no start is found, or the data bit at the start is 0, then `found` = 0, `remain` equals the requested size, and no byte is written.
- R6: The bits after the start bit are packed LSB first. Each full byte is written once, with `wr_addr` = 0, 1, 2 and so on. No two writes occur in consecutive cycles.
- R7: Extraction stops at the first bit whose validity bit is 1, and that bit is not taken. `remain` = size minus the number of bits taken.
- R8: Extraction stops once the requested size has been taken, giving `remain` = 0. A requested size of 0 takes nothing. A final partial byte of k bits is written right-aligned, with its upper 8-k bits at 0.
- R9: `done` is a one-cycle pulse. `found` and `remain` change only with `done` and hold until the next `done`. Counting from the edge that samples `start`, `done` rises 1 cycle later when extraction is refused, and n+2 cycles later when a start is accepted and n bits are taken.
- R10: A `start` pulse that arrives while an extraction is running is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an extraction; sampled only when idle |
| fsk_mode | input | 1 | 0 = amplitude-keyed start rule, 1 = frequency-keyed pattern rule |
| req_size | input | SW (8) | Number of bits requested |
| rd_addr | output | $clog2(DEPTH) (6) | Byte address of the capture memories |
| rd_data | input | 8 | Data byte at rd_addr, same cycle |
| rd_valid | input | 8 | Validity byte at rd_addr, same cycle, 0 = clean |
| wr_en | output | 1 | Output byte write strobe |
| wr_addr | output | SW-3 (5) | Output byte index |
| wr_data | output | 8 | Output byte |
| done | output | 1 | One-cycle completion pulse |
| found | output | 1 | Start located and start bit is 1 |
| remain | output | SW (8) | Requested bits not extracted |

## Verification
The completion pulse is due 1 cycle after the sampling edge when extraction is refused, and n+2 cycles after it when n bits are taken. The bench counts rising edges from the edge that samples `start` and compares that count with the expected latency for every vector. Byte writes are captured at the falling edge, half a cycle after the edge that registered them. `found` and `remain` are read on the falling edge where `done` is first seen high, and read again some cycles later to confirm they have held.

// File: rtl/sof_bit_extractor.sv
module sof_bit_extractor #(
  parameter int DEPTH = 40,
  parameter int SW    = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int OW   = SW - 3,
  localparam int PW   = SW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          fsk_mode,
  input  logic [SW-1:0] req_size,
  output logic [AW-1:0] rd_addr,
  input  logic [7:0]    rd_data,
  input  logic [7:0]    rd_valid,
  output logic          wr_en,
  output logic [OW-1:0] wr_addr,
  output logic [7:0]    wr_data,
  output logic          done,
  output logic          found,
  output logic [SW-1:0] remain
);

  typedef enum logic [1:0] {IDLE, SEEK, RUN} st_t;

  st_t           st;
  logic          fsk;
  logic [SW-1:0] cnt;
  logic [SW-1:0] nb;
  logic [PW-1:0] pos;
  logic [7:0]    acc;

  logic          ask_hit;
  logic [2:0]    ask_pos;

  always_comb begin
    ask_hit = 1'b0;
    ask_pos = 3'd0;
    for (int i = 6; i >= 0; i--) begin
      if (!rd_valid[7-i]) begin
        ask_hit = 1'b1;
        ask_pos = 3'(i);
      end
    end
  end

  wire       pat_hi   = (rd_data[7:4] == 4'b0101) && (rd_valid[7:4] == 4'b0000);
  wire       pat_lo   = (rd_data[6:3] == 4'b0101) && (rd_valid[6:3] == 4'b0000);
  wire       hit      = fsk ? (pat_hi | pat_lo) : ask_hit;
  wire [2:0] spos     = fsk ? (pat_hi ? 3'd3 : 3'd4) : ask_pos;
  wire       start_ok = hit && rd_data[~spos];

  wire       bit_d    = rd_data[~pos[2:0]];
  wire       bit_v    = rd_valid[~pos[2:0]];
  wire       stop     = (cnt == '0) || bit_v;
  wire [7:0] acc_n    = {bit_d, acc[7:1]};
  wire [3:0] shamt    = 4'd8 - {1'b0, nb[2:0]};

  assign rd_addr = (st == RUN) ? AW'(pos >> 3) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= IDLE;
      fsk     <= 1'b0;
      cnt     <= '0;
      nb      <= '0;
      pos     <= '0;
      acc     <= '0;
      wr_en   <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
      done    <= 1'b0;
      found   <= 1'b0;
      remain  <= '0;
    end else begin
      wr_en <= 1'b0;
      done  <= 1'b0;
      case (st)
        IDLE: if (start) begin
          cnt <= req_size;
          fsk <= fsk_mode;
          st  <= SEEK;
        end
        SEEK: if (start_ok) begin
          pos <= PW'(spos) + PW'(1);
          nb  <= '0;
          acc <= '0;
          st  <= RUN;
        end else begin
          done   <= 1'b1;
          found  <= 1'b0;
          remain <= cnt;
          st     <= IDLE;
        end
        RUN: if (stop) begin
          done   <= 1'b1;
          found  <= 1'b1;
          remain <= cnt;
          st     <= IDLE;
          if (nb[2:0] != 3'd0) begin
            wr_en   <= 1'b1;
            wr_addr <= nb[SW-1:3];
            wr_data <= acc >> shamt;
          end
        end else begin
          acc <= acc_n;
          pos <= pos + PW'(1);
          cnt <= cnt - SW'(1);
          nb  <= nb + SW'(1);
          if (nb[2:0] == 3'd7) begin
            wr_en   <= 1'b1;
            wr_addr <= nb[SW-1:3];
            wr_data <= acc_n;
          end
        end
        default: st <= IDLE;
      endcase
    end
  end

endmodule

// File: rtl/sof_bit_extractor_chk.sv
module sof_bit_extractor_chk #(
  parameter int SW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          done,
  input logic          found,
  input logic          wr_en,
  input logic [SW-1:0] remain
);

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R6
  wr_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !wr_en);

  // R5
  refused_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !found) |-> !wr_en);

  // R9
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done |=> ($stable(found) && $stable(remain)) || done);

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |=> (!done && !wr_en && !found && remain == '0));

endmodule

bind sof_bit_extractor sof_bit_extractor_chk #(.SW(SW)) u_chk (
  .clk(clk), .rst_n(rst_n), .done(done), .found(found),
  .wr_en(wr_en), .remain(remain)
);

// File: tb/sof_bit_extractor_bench.sv
`timescale 1ns/1ps
module sof_bit_extractor_bench;
  localparam int DEPTH = 40;
  localparam int SW = 8;
  localparam int AW = $clog2(DEPTH);
  localparam int OW = SW - 3;

  typedef struct packed {
    logic       fsk;
    logic [7:0] size, d0, v0, d1, v1;
    logic       fnd;
    logic [7:0] rem, nwr, b0, b1, lat;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 8'd20, 8'h80, 8'h00, 8'hA5, 8'h00, 1'b1, 8'd5,  8'd2, 8'h80, 8'h52, 8'd17},
    '{1'b0, 8'd4,  8'h80, 8'h00, 8'hA5, 8'h00, 1'b1, 8'd0,  8'd1, 8'h00, 8'h00, 8'd6},
    '{1'b0, 8'd30, 8'h20, 8'hC0, 8'hFF, 8'h0F, 1'b1, 8'd21, 8'd2, 8'hE0, 8'h01, 8'd11},
    '{1'b0, 8'd12, 8'h00, 8'hFE, 8'h00, 8'hFF, 1'b0, 8'd12, 8'd0, 8'h00, 8'h00, 8'd1},
    '{1'b0, 8'd9,  8'h00, 8'h00, 8'h00, 8'hFF, 1'b0, 8'd9,  8'd0, 8'h00, 8'h00, 8'd1},
    '{1'b1, 8'd10, 8'h50, 8'h0F, 8'h00, 8'h00, 1'b1, 8'd10, 8'd0, 8'h00, 8'h00, 8'd2},
    '{1'b1, 8'd8,  8'h28, 8'h00, 8'hC3, 8'h00, 1'b1, 8'd0,  8'd1, 8'h18, 8'h00, 8'd10},
    '{1'b1, 8'd7,  8'h50, 8'h80, 8'h00, 8'hFF, 1'b0, 8'd7,  8'd0, 8'h00, 8'h00, 8'd1},
    '{1'b0, 8'd0,  8'h80, 8'h00, 8'hA5, 8'h00, 1'b1, 8'd0,  8'd0, 8'h00, 8'h00, 8'd2},
    '{1'b0, 8'd5,  8'h03, 8'hFC, 8'h00, 8'hFF, 1'b1, 8'd4,  8'd1, 8'h01, 8'h00, 8'd3}
  };
  localparam string TAG [NV] = '{
    "R7 R6 R2", "R8 R3", "R3 R7 R8", "R3 R5", "R5",
    "R4 R7", "R4 R6 R8", "R4 R5", "R8 R9", "R3 R8"
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic fsk_mode = 1'b0;
  logic [SW-1:0] req_size = '0;
  logic [AW-1:0] rd_addr;
  logic [7:0] rd_data, rd_valid;
  logic wr_en;
  logic [OW-1:0] wr_addr;
  logic [7:0] wr_data;
  logic done, found;
  logic [SW-1:0] remain;

  logic [7:0] dmem [DEPTH];
  logic [7:0] vmem [DEPTH];
  logic [7:0] omem [32];
  int nwr = 0;
  int ndone = 0;
  int nchk = 0;
  int nerr = 0;

  always #2.5 clk = ~clk;

  assign rd_data  = (int'(rd_addr) < DEPTH) ? dmem[rd_addr] : 8'h00;
  assign rd_valid = (int'(rd_addr) < DEPTH) ? vmem[rd_addr] : 8'hFF;

  sof_bit_extractor #(.DEPTH(DEPTH), .SW(SW)) u_sof_bit_extractor (
    .clk(clk), .rst_n(rst_n), .start(start), .fsk_mode(fsk_mode),
    .req_size(req_size), .rd_addr(rd_addr), .rd_data(rd_data),
    .rd_valid(rd_valid), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .done(done), .found(found), .remain(remain)
  );

  always @(negedge clk) begin
    if (wr_en) begin
      omem[wr_addr] = wr_data;
      nwr = nwr + 1;
    end
    if (done) ndone = ndone + 1;
  end

  task automatic chk(input string r, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", r, act, exp);
    end
  endtask

  task automatic load(input vec_t v);
    for (int i = 0; i < DEPTH; i++) begin
      dmem[i] = 8'h00;
      vmem[i] = 8'hFF;
    end
    dmem[0] = v.d0; vmem[0] = v.v0;
    dmem[1] = v.d1; vmem[1] = v.v1;
    for (int i = 0; i < 32; i++) omem[i] = 8'hEE;
    nwr = 0;
    ndone = 0;
  endtask

  task automatic run(input vec_t v, output int lat);
    @(negedge clk);
    fsk_mode = v.fsk;
    req_size = v.size;
    start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    lat = 0;
    while (!done && lat < 1000) begin
      @(posedge clk);
      lat++;
      @(negedge clk);
    end
  endtask

  initial begin
    #(200000 * 5);
    nerr++;
    nchk++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    int lat;
    for (int i = 0; i < DEPTH; i++) begin
      dmem[i] = 8'h00;
      vmem[i] = 8'hFF;
    end
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk("R1 done", int'(done), 0);
    chk("R1 wr_en", int'(wr_en), 0);
    chk("R1 found", int'(found), 0);
    chk("R1 remain", int'(remain), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 done after release", int'(done), 0);

    for (int k = 0; k < NV; k++) begin
      load(VEC[k]);
      run(VEC[k], lat);
      chk({TAG[k], " found"}, int'(found), int'(VEC[k].fnd));
      chk({TAG[k], " remain"}, int'(remain), int'(VEC[k].rem));
      chk({TAG[k], " R9 latency"}, lat, int'(VEC[k].lat));
      repeat (3) @(negedge clk);
      chk({TAG[k], " writes"}, nwr, int'(VEC[k].nwr));
      if (VEC[k].nwr >= 1) chk({TAG[k], " byte0"}, int'(omem[0]), int'(VEC[k].b0));
      if (VEC[k].nwr >= 2) chk({TAG[k], " byte1"}, int'(omem[1]), int'(VEC[k].b1));
      chk({TAG[k], " R9 single done"}, ndone, 1);
      chk({TAG[k], " R9 remain held"}, int'(remain), int'(VEC[k].rem));
    end

    // R10: a second start during the run must not change the result
    load(VEC[0]);
    @(negedge clk);
    fsk_mode = 1'b0;
    req_size = 8'd20;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
    fsk_mode = 1'b1;
    req_size = 8'd1;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (40) @(negedge clk);
    chk("R10 done count", ndone, 1);
    chk("R10 remain", int'(remain), 5);
    chk("R10 found", int'(found), 1);
    chk("R10 byte1", int'(omem[1]), 8'h52);

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule